// File: doc/BRIEF.md
# Double-to-Int32 Converter

This block turns a packed 64-bit IEEE-754 double into a 32-bit integer. The integer is signed or unsigned, chosen for each operand. A 2-bit mode selects the rounding direction. A separate truncate input overrides that mode and forces round-toward-zero, so a pipeline can issue truncating conversions without rewriting the mode.

With each result the block returns three flags:
- invalid: the value cannot be represented, or the operand is a NaN.
- inexact: a fraction was discarded.
- input-denormal: the operand was subnormal.

Out-of-range values saturate. NaNs are handled differently for the two integer kinds. Magnitudes below one half follow dedicated rules under directed rounding.

An operand is accepted on any cycle where `in_valid` is high. The result and flags appear registered on the next cycle, together with `out_valid`. Between results the outputs keep the last value.

Top module: `fp64_int_cvt`

## Requirements
- R1: Rounding mode `in_rmode`: 2'b00 is to nearest with ties to even, 2'b01 is toward plus infinity, 2'b10 is toward minus infinity, 2'b11 is toward zero. Directed modes add one to the magnitude only when a fraction is discarded and the direction moves away from zero for that sign.
- R2: When `in_trunc` is 1, rounding is toward zero whatever `in_rmode` holds.
- R3: A non-NaN operand whose magnitude is at least 2^32 (biased exponent at least 1023+32, infinities included) saturates, and invalid is raised.
  - Unsigned results: 0xFFFFFFFF for positive operands, 0 for negative ones.
  - Signed results: 0x7FFFFFFF for positive operands, 0x80000000 for negative ones.
- R4: A NaN of either sign gives 0xFFFFFFFF with invalid for an unsigned result, and 0 with invalid for a signed result.
- R5: For an unsigned result, a round-up from 0xFFFFFFFF does not wrap. The result stays 0xFFFFFFFF with invalid, and inexact is also raised.
- R6: For an unsigned result with magnitude at least 0.5, a negative operand whose rounded magnitude is nonzero gives 0 with invalid and without inexact. No negative non-NaN operand ever gives a nonzero unsigned result.
- R7: For a signed result, a rounded magnitude above 0x7FFFFFFF (above 0x80000000 for negative operands) clamps to that bound. Invalid is raised and inexact is not.
- R8: Within range, inexact is raised exactly when a nonzero fraction is discarded. A signed result for a negative operand is the two's complement of the rounded magnitude.
- R9: A nonzero operand below 0.5 in magnitude (biased exponent below 1022) gives 0 with inexact, with these exceptions:
  - A positive operand rounded toward plus infinity gives 1.
  - A negative operand rounded toward minus infinity gives 0xFFFFFFFF when signed, or 0 with invalid when unsigned.
- R10: A subnormal operand (exponent field 0, fraction nonzero) raises input-denormal. A zero of either sign gives 0 with no flag.
- R11: Exactly one cycle after each accepted operand, `out_valid` is high for one cycle with that operand's result. Otherwise `out_valid` is low and the outputs hold their value. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_fp | input | 64 | Packed double: sign at bit 63, exponent in bits 62:52, fraction in bits 51:0 |
| in_signed | input | 1 | 1 selects a signed result, 0 selects an unsigned result |
| in_rmode | input | 2 | Rounding mode, encoded as in R1 |
| in_trunc | input | 1 | Forces round-toward-zero |
| out_valid | output | 1 | Result present this cycle |
| out_int | output | 32 | Converted integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_denorm | output | 1 | Input-denormal flag |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent, a 52-bit fraction and a 32-bit integer. This lets it form operands from real numbers in the bench and compute expected results by real-valued floor and fraction arithmetic, with no bit-level shifting. With these sizes the edges at 2^31 and 2^32 can be reached exactly:
- the signed clamp on each side;
- the unsigned carry out of 0xFFFFFFFF;
- ties to even just below both limits.

A quarter-step sweep in every mode, for both integer kinds, covers the tie and sign rules near zero. The half-magnitude boundary separates the two below-one paths.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO,
    CL_SUB,
    CL_NORM,
    CL_INF,
    CL_NAN
  } fclass_e;

  // Decide whether the truncated magnitude gains one.
  // lsb: integer LSB, half: first discarded bit, sticky: OR of the rest.
  function automatic logic round_up(rmode_e rm, logic neg, logic lsb,
                                    logic half, logic sticky);
    logic up;
    case (rm)
      RM_NEAR: up = half & (sticky | lsb);
      RM_UP:   up = ~neg & (half | sticky);
      RM_DOWN: up = neg & (half | sticky);
      default: up = 1'b0;
    endcase
    return up;
  endfunction

endpackage

// File: rtl/fpcvt_classify.sv
module fpcvt_classify
  import fpcvt_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] bits_i,
  output logic                  sign_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [FRAC_W-1:0]     frac_o,
  output fclass_e               cls_o
);

  localparam int W = EXP_W + FRAC_W + 1;

  assign sign_o = bits_i[W-1];
  assign exp_o  = bits_i[W-2:FRAC_W];
  assign frac_o = bits_i[FRAC_W-1:0];

  always_comb begin
    if (exp_o == '0)
      cls_o = (frac_o == '0) ? CL_ZERO : CL_SUB;
    else if (&exp_o)
      cls_o = (frac_o == '0) ? CL_INF : CL_NAN;
    else
      cls_o = CL_NORM;
  end

endmodule

// File: rtl/fpcvt_align.sv
module fpcvt_align #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [INT_W-1:0]  ipart_o,
  output logic              half_o,
  output logic              sticky_o,
  output logic              window_o,
  output logic              big_o
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int LO   = BIAS - 1;
  localparam int HI   = BIAS + INT_W - 1;
  localparam int MW   = FRAC_W + 1;
  localparam int TW   = MW + INT_W;
  localparam int SHW  = $clog2(INT_W + 1);

  logic [SHW-1:0] shamt;
  logic [TW-1:0]  placed;

  assign big_o    = int'(exp_i) > HI;
  assign window_o = (int'(exp_i) >= LO) && !big_o;
  assign shamt    = window_o ? SHW'(int'(exp_i) - LO) : '0;

  // Binary point sits between bit MW and bit MW-1 after the shift.
  assign placed   = {{INT_W{1'b0}}, 1'b1, frac_i} << shamt;

  assign ipart_o  = placed[TW-1:MW];
  assign half_o   = placed[MW-1];
  assign sticky_o = |placed[MW-2:0];

endmodule

// File: rtl/fpcvt_resolve.sv
module fpcvt_resolve
  import fpcvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  fclass_e          cls_i,
  input  logic             sign_i,
  input  logic             signed_i,
  input  rmode_e           rm_i,
  input  logic [INT_W-1:0] ipart_i,
  input  logic             half_i,
  input  logic             sticky_i,
  input  logic             window_i,
  input  logic             big_i,
  output logic [INT_W-1:0] res_o,
  output logic             inv_o,
  output logic             inx_o,
  output logic             ev_sat_o,
  output logic             ev_low_o,
  output logic             ev_clip_o
);

  localparam logic [INT_W-1:0] UMAX = '1;
  localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};

  logic             up;
  logic             frac_nz;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] lim;

  assign up       = round_up(rm_i, sign_i, ipart_i[0], half_i, sticky_i);
  assign frac_nz  = half_i | sticky_i;
  assign ev_sat_o = big_i;
  assign ev_low_o = !big_i && !window_i && (cls_i != CL_ZERO);

  always_comb begin
    res_o     = '0;
    inv_o     = 1'b0;
    inx_o     = 1'b0;
    ev_clip_o = 1'b0;
    mag       = ipart_i;
    lim       = sign_i ? SMIN : SMAX;
    if (cls_i == CL_NAN && signed_i) begin
      inv_o = 1'b1;
    end else if (big_i) begin
      inv_o = 1'b1;
      if (signed_i)
        res_o = sign_i ? SMIN : SMAX;
      else
        res_o = (sign_i && cls_i != CL_NAN) ? '0 : UMAX;
    end else if (window_i) begin
      if (!signed_i) begin
        if (up) begin
          if (ipart_i != UMAX) mag = ipart_i + INT_W'(1);
          else                 inv_o = 1'b1;
        end
        if (mag != '0 && sign_i) begin
          res_o = '0;
          inv_o = 1'b1;
        end else begin
          res_o = mag;
          inx_o = frac_nz;
        end
      end else begin
        if (up && ipart_i != UMAX) mag = ipart_i + INT_W'(1);
        if (mag > lim) begin
          mag       = lim;
          inv_o     = 1'b1;
          ev_clip_o = 1'b1;
        end else begin
          inx_o = frac_nz;
        end
        res_o = sign_i ? (~mag + INT_W'(1)) : mag;
      end
    end else if (cls_i != CL_ZERO) begin
      inx_o = 1'b1;
      if (rm_i == RM_UP && !sign_i) begin
        res_o = INT_W'(1);
      end else if (rm_i == RM_DOWN && sign_i) begin
        if (signed_i) res_o = UMAX;
        else          inv_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fp64_int_cvt.sv
module fp64_int_cvt
  import fpcvt_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] in_fp,
  input  logic                  in_signed,
  input  logic [1:0]            in_rmode,
  input  logic                  in_trunc,
  output logic                  out_valid,
  output logic [INT_W-1:0]      out_int,
  output logic                  out_invalid,
  output logic                  out_inexact,
  output logic                  out_denorm
);

  logic              sign_w;
  logic [EXP_W-1:0]  exp_w;
  logic [FRAC_W-1:0] frac_w;
  fclass_e           cls_w;
  rmode_e            rm_eff;
  logic [INT_W-1:0]  ipart_w;
  logic              half_w;
  logic              sticky_w;
  logic              window_w;
  logic              big_w;
  logic [INT_W-1:0]  res_w;
  logic              inv_w;
  logic              inx_w;
  // Named internal events, observed by the bound checker.
  logic              ev_sat;
  logic              ev_low;
  logic              ev_clip;

  assign rm_eff = in_trunc ? RM_ZERO : rmode_e'(in_rmode);

  fpcvt_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_class (
    .bits_i (in_fp),
    .sign_o (sign_w),
    .exp_o  (exp_w),
    .frac_o (frac_w),
    .cls_o  (cls_w)
  );

  fpcvt_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .exp_i    (exp_w),
    .frac_i   (frac_w),
    .ipart_o  (ipart_w),
    .half_o   (half_w),
    .sticky_o (sticky_w),
    .window_o (window_w),
    .big_o    (big_w)
  );

  fpcvt_resolve #(.INT_W(INT_W)) u_resolve (
    .cls_i     (cls_w),
    .sign_i    (sign_w),
    .signed_i  (in_signed),
    .rm_i      (rm_eff),
    .ipart_i   (ipart_w),
    .half_i    (half_w),
    .sticky_i  (sticky_w),
    .window_i  (window_w),
    .big_i     (big_w),
    .res_o     (res_w),
    .inv_o     (inv_w),
    .inx_o     (inx_w),
    .ev_sat_o  (ev_sat),
    .ev_low_o  (ev_low),
    .ev_clip_o (ev_clip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_denorm  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= res_w;
        out_invalid <= inv_w;
        out_inexact <= inx_w;
        out_denorm  <= (cls_w == CL_SUB);
      end
    end
  end

endmodule

// File: rtl/fp64_int_cvt_chk.sv
module fp64_int_cvt_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] in_fp,
  input logic                  in_signed,
  input logic                  out_valid,
  input logic [INT_W-1:0]      out_int,
  input logic                  out_invalid,
  input logic                  out_inexact,
  input logic                  out_denorm,
  input logic                  ev_sat,
  input logic                  ev_low,
  input logic                  ev_clip
);

  localparam int W = EXP_W + FRAC_W + 1;

  logic in_neg, in_nan, in_sub, in_zero;
  assign in_neg  = in_fp[W-1];
  assign in_nan  = (&in_fp[W-2:FRAC_W]) && (in_fp[FRAC_W-1:0] != '0);
  assign in_sub  = (in_fp[W-2:FRAC_W] == '0) && (in_fp[FRAC_W-1:0] != '0);
  assign in_zero = (in_fp[W-2:0] == '0);

  p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_int) && $stable(out_invalid) && $stable(out_inexact));

  p_sat_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_sat) |=> out_invalid);

  p_nan_signed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed && in_nan) |=> (out_int == '0) && out_invalid);

  p_uns_neg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_signed && in_neg && !in_nan) |=> (out_int == '0));

  p_clip_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed && ev_clip) |=> out_invalid && !out_inexact);

  p_low_inexact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_low) |=> out_inexact);

  p_zero_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zero) |=> (out_int == '0) && !out_invalid && !out_inexact && !out_denorm);

  p_denorm_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sub) |=> out_denorm);

endmodule

bind fp64_int_cvt fp64_int_cvt_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_fp       (in_fp),
  .in_signed   (in_signed),
  .out_valid   (out_valid),
  .out_int     (out_int),
  .out_invalid (out_invalid),
  .out_inexact (out_inexact),
  .out_denorm  (out_denorm),
  .ev_sat      (ev_sat),
  .ev_low      (ev_low),
  .ev_clip     (ev_clip)
);

// File: tb/fp64_int_cvt_tb_top.sv
module fp64_int_cvt_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_fp = '0;
  logic        in_signed = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic        in_trunc = 1'b0;
  logic        out_valid;
  logic [31:0] out_int;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_denorm;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  fp64_int_cvt dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fp(in_fp),
    .in_signed(in_signed), .in_rmode(in_rmode), .in_trunc(in_trunc),
    .out_valid(out_valid), .out_int(out_int), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_denorm(out_denorm)
  );

  // Expected value from real-number arithmetic.
  function automatic void ref_cvt(input logic [63:0] b, input logic sg,
      input logic [1:0] rm_in, input logic tr, output logic [31:0] res,
      output logic inv, output logic inx, output logic den);
    logic s; logic [10:0] e; logic [51:0] f; logic [1:0] rm;
    real a, fl, fr; logic up; longint mag, lim;
    s = b[63]; e = b[62:52]; f = b[51:0];
    rm = tr ? 2'b11 : rm_in;
    res = '0; inv = 1'b0; inx = 1'b0; up = 1'b0;
    den = (e == 11'd0) && (f != 52'd0);
    if (e == 11'h7FF && f != 52'd0) begin
      inv = 1'b1; res = sg ? 32'h0 : 32'hFFFFFFFF; return;
    end
    if (e == 11'h7FF) a = 1.0e300;
    else begin a = $bitstoreal(b); if (a < 0.0) a = -a; end
    if (a >= 4294967296.0) begin
      inv = 1'b1;
      if (sg) res = s ? 32'h80000000 : 32'h7FFFFFFF;
      else    res = s ? 32'h0 : 32'hFFFFFFFF;
      return;
    end
    if (a == 0.0) return;
    if (a < 0.5) begin
      inx = 1'b1;
      if (rm == 2'b01 && !s) res = 32'd1;
      else if (rm == 2'b10 && s) begin
        if (sg) res = 32'hFFFFFFFF; else inv = 1'b1;
      end
      return;
    end
    fl = $floor(a); fr = a - fl; mag = longint'(fl);
    case (rm)
      2'b00: up = (fr > 0.5) || (fr == 0.5 && mag[0]);
      2'b01: up = !s && (fr > 0.0);
      2'b10: up = s && (fr > 0.0);
      default: up = 1'b0;
    endcase
    if (!sg) begin
      if (up) begin
        if (mag == 64'hFFFFFFFF) inv = 1'b1; else mag = mag + 1;
      end
      if (mag != 0 && s) begin res = '0; inv = 1'b1; end
      else begin res = 32'(mag); inx = (fr > 0.0); end
    end else begin
      if (up && mag < 64'hFFFFFFFF) mag = mag + 1;
      lim = s ? 64'd2147483648 : 64'd2147483647;
      if (mag > lim) begin mag = lim; inv = 1'b1; end
      else inx = (fr > 0.0);
      res = s ? 32'(-mag) : 32'(mag);
    end
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got valid/int/inv/inx/den=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] b, input logic sg, input logic [1:0] rm,
                       input logic tr, input string tag);
    logic [31:0] er; logic ei, ex, ed;
    ref_cvt(b, sg, rm, tr, er, ei, ex, ed);
    @(negedge clk);
    in_fp = b; in_signed = sg; in_rmode = rm; in_trunc = tr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, out_int, out_invalid, out_inexact, out_denorm},
               {1'b1, er, ei, ex, ed});
  endtask

  task automatic applyr(input real v, input logic sg, input logic [1:0] rm,
                        input logic tr, input string tag);
    apply($realtobits(v), sg, rm, tr, tag);
  endtask

  task automatic t_reset;
    check("R11 reset", {out_valid, out_int, out_invalid, out_inexact, out_denorm}, 36'h0);
  endtask

  task automatic t_modes;
    applyr(2.5, 0, 2'b00, 0, "R1 tie even down");
    applyr(3.5, 0, 2'b00, 0, "R1 tie even up");
    applyr(-2.5, 1, 2'b00, 0, "R1 signed tie");
    applyr(2.3, 0, 2'b01, 0, "R1 up");
    applyr(2.3, 0, 2'b10, 0, "R1 down");
    applyr(-2.3, 1, 2'b10, 0, "R1 down neg");
    applyr(-2.3, 1, 2'b01, 0, "R1 up neg");
    applyr(7.0, 1, 2'b01, 0, "R8 exact");
    applyr(123456.75, 1, 2'b00, 0, "R8 inexact");
  endtask

  task automatic t_trunc;
    applyr(2.7, 0, 2'b00, 1, "R2 trunc over nearest");
    applyr(-2.7, 1, 2'b10, 1, "R2 trunc over down");
    applyr(0.3, 0, 2'b01, 1, "R2 trunc low");
  endtask

  task automatic t_sat;
    applyr(4294967295.0, 0, 2'b00, 0, "R3 max exact");
    applyr(4294967296.0, 0, 2'b00, 0, "R3 unsigned sat");
    applyr(-4294967296.0, 0, 2'b00, 0, "R3 unsigned neg sat");
    apply(64'h7FF0000000000000, 1, 2'b00, 0, "R3 +inf signed");
    applyr(-1.0e20, 1, 2'b00, 0, "R3 signed neg sat");
  endtask

  task automatic t_nan;
    apply(64'h7FF8000000000000, 0, 2'b00, 0, "R4 qnan unsigned");
    apply(64'h7FF8000000000000, 1, 2'b00, 0, "R4 qnan signed");
    apply(64'hFFF0000000000001, 0, 2'b10, 0, "R4 neg snan unsigned");
  endtask

  task automatic t_ucarry;
    applyr(4294967295.5, 0, 2'b01, 0, "R5 carry up");
    applyr(4294967295.5, 0, 2'b00, 0, "R5 carry tie");
    applyr(4294967294.5, 0, 2'b00, 0, "R5 tie even no carry");
  endtask

  task automatic t_uneg;
    applyr(-3.0, 0, 2'b00, 0, "R6 neg exact");
    applyr(-0.7, 0, 2'b00, 0, "R6 neg rounds to one");
    applyr(-0.5, 0, 2'b00, 0, "R6 neg tie to zero");
  endtask

  task automatic t_sclamp;
    applyr(2147483648.0, 1, 2'b00, 0, "R7 clamp pos");
    applyr(-2147483648.0, 1, 2'b00, 0, "R7 exact min");
    applyr(-2147483648.5, 1, 2'b10, 0, "R7 clamp neg");
    applyr(2147483647.5, 1, 2'b00, 0, "R7 tie over max");
  endtask

  task automatic t_low;
    applyr(0.25, 1, 2'b01, 0, "R9 pos up");
    applyr(-0.25, 1, 2'b10, 0, "R9 neg down signed");
    applyr(-0.25, 0, 2'b10, 0, "R9 neg down unsigned");
    applyr(0.25, 0, 2'b00, 0, "R9 nearest");
    applyr(-0.25, 1, 2'b01, 0, "R9 neg up");
  endtask

  task automatic t_denorm_zero;
    apply(64'h0000000000000001, 0, 2'b01, 0, "R10 subnormal up");
    apply(64'h8000000000000001, 1, 2'b10, 0, "R10 neg subnormal down");
    apply(64'h0000000000000000, 1, 2'b01, 0, "R10 pos zero");
    apply(64'h8000000000000000, 0, 2'b10, 0, "R10 neg zero");
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_fp = $realtobits(5.0); in_signed = 1'b1; in_rmode = 2'b00; in_trunc = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_fp = $realtobits(-9.5);
    check("R11 first of pair", {out_valid, out_int, out_invalid, out_inexact, out_denorm},
          {1'b1, 32'd5, 3'b000});
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second of pair", {out_valid, out_int, out_invalid, out_inexact, out_denorm},
          {1'b1, 32'hFFFFFFF6, 3'b010});
    @(negedge clk);
    check("R11 idle hold", {out_valid, out_int, out_invalid, out_inexact, out_denorm},
          {1'b0, 32'hFFFFFFF6, 3'b010});
  endtask

  task automatic t_sweep;
    for (int k = -40; k <= 40; k++)
      for (int m = 0; m < 4; m++)
        for (int g = 0; g < 2; g++)
          applyr(real'(k) / 4.0, g[0], m[1:0], 1'b0, "R8 sweep");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_modes();
    t_trunc();
    t_sat();
    t_nan();
    t_ucarry();
    t_uneg();
    t_sclamp();
    t_low();
    t_denorm_zero();
    t_stream();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule